// File: doc/BRIEF.md
# SPI Byte Master with Select-Line Arbitration

This block is a byte-wide SPI master. Software loads a byte and pulses a start strobe. The engine then generates SCK from a programmable divider and shifts the byte out on MOSI, most significant bit first. On the same clock edges it gathers eight MISO bits into a received byte. Clock polarity and phase are configurable. A one-cycle done pulse marks the capture of the last bit.

A two-bit select-mode field sets the role of the NSS pin:

| Mode | NSS role |
|------|----------|
| 00 | Unused. The pin is neither driven nor observed. |
| 01 | Input. A falling edge on NSS means another master has taken the bus. |
| 1x | Output. The pin carries the low bit of the mode field. |

In mode 01, the NSS input passes through a two-flop synchronizer. If a falling edge arrives while this block holds master status, the block does three things:
- it gives up master status;
- it stops any transfer in flight, returns SCK to idle and suppresses the done pulse;
- it raises a sticky fault flag that stays set until software clears it.

Top module: `spi_mm_master`

## Requirements
- R1: Bits leave on `mosi_o` most significant bit first. The eight `miso_i` bits are assembled so that the first bit sampled lands in bit 7 of `rx_byte`.
- R2: While a transfer runs, SCK makes exactly 8 pulses with a period of 2*(`cfg_div`+1) clock cycles. Whenever no transfer runs, `sck_o` holds the level of `cfg_cpol`.
- R3: The leading edge is the first SCK edge away from the idle level. With `cfg_cpha`=0, MISO is sampled on leading edges and MOSI changes on trailing edges. With `cfg_cpha`=1, MOSI changes on leading edges after the first one and MISO is sampled on trailing edges.
- R4: `busy` is high from the clock edge that accepts `start` until the final SCK edge. `done` is high for exactly one cycle, starting at the clock edge that captures the eighth MISO bit. `rx_byte` changes at that same edge.
- R5: `start` is ignored while `busy` is high, and also while `mst` is low.
- R6: In mode 01, a falling edge on `nss_i` while `mst` is high acts within three clock edges. It clears `mst`, ends the transfer without a `done` pulse, returns SCK to idle and sets `fault`. A falling edge while `mst` is low has no effect.
- R7: `fault` stays set until a `fault_clr` pulse clears it.
- R8: In modes 00, 10 and 11, activity on `nss_i` has no effect: transfers complete and `fault` stays low.
- R9: `nss_oe` equals bit 1 of `cfg_mode`. When bit 1 is set, `nss_o` equals bit 0 of `cfg_mode`; otherwise `nss_o` is high.
- R10: After reset, `mst`, `busy`, `done` and `fault` are low, and `rx_byte` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_mode | input | 2 | Select-pin mode |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | Sampling phase |
| cfg_div | input | DIVW | Half-period length minus one, in clock cycles |
| mst_set | input | 1 | Pulse that takes master status |
| mst | output | 1 | Master status |
| start | input | 1 | Start strobe for one byte |
| tx_byte | input | DW | Byte to send |
| rx_byte | output | DW | Last byte received |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Sticky mode-fault flag |
| fault_clr | input | 1 | Clears the fault flag |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| nss_i | input | 1 | Select pin, input role |
| nss_o | output | 1 | Select pin, output level |
| nss_oe | output | 1 | Select pin, output enable |

## Verification
A slave model in the bench follows all four polarity and phase combinations at divider values down to zero. Zero is where a phase error would sample MISO one half-period early and return a byte shifted by one bit. Mid-transfer tests cover three cases:
- A second start strobe must not restart the byte. A design that accepted it would emit more than eight pulses.
- A select-line drop in mode 01 must abort the transfer. A design that only flagged it would still finish the byte and pulse `done`.
- Select-line drops in the other modes, or while not master, must be ignored. A design that decoded the mode loosely would raise a false fault.

// File: rtl/spi_mm_master.sv
module spi_mm_master #(
  parameter int DW   = 8,
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      cfg_mode,
  input  logic            cfg_cpol,
  input  logic            cfg_cpha,
  input  logic [DIVW-1:0] cfg_div,
  input  logic            mst_set,
  output logic            mst,
  input  logic            start,
  input  logic [DW-1:0]   tx_byte,
  output logic [DW-1:0]   rx_byte,
  output logic            busy,
  output logic            done,
  output logic            fault,
  input  logic            fault_clr,
  output logic            sck_o,
  output logic            mosi_o,
  input  logic            miso_i,
  input  logic            nss_i,
  output logic            nss_o,
  output logic            nss_oe
);

  localparam int EW = $clog2(2 * DW);
  localparam logic [EW-1:0] ELAST = EW'(2 * DW - 1);

  logic [2:0]      nss_q;
  logic [DIVW-1:0] cnt;
  logic [EW-1:0]   edg;
  logic [DW-1:0]   sh, rsh;
  logic            sck_q;

  wire nss_fall = (cfg_mode == 2'b01) && nss_q[2] && !nss_q[1];
  wire abort    = nss_fall && mst;
  wire go       = start && mst && !busy && !abort;
  wire tick     = busy && (cnt == cfg_div);
  wire lead     = ~edg[0];
  wire smp      = tick && (lead ^ cfg_cpha);
  wire shf      = tick && !(lead ^ cfg_cpha) && (edg != '0);
  wire smp_last = smp && (edg[EW-1:1] == {(EW-1){1'b1}});
  wire [DW-1:0] rnext = {rsh[DW-2:0], miso_i};

  assign sck_o  = busy ? sck_q : cfg_cpol;
  assign mosi_o = sh[DW-1];
  assign nss_oe = cfg_mode[1];
  assign nss_o  = cfg_mode[1] ? cfg_mode[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nss_q   <= 3'b111;
      mst     <= 1'b0;
      fault   <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      cnt     <= '0;
      edg     <= '0;
      sh      <= '0;
      rsh     <= '0;
      rx_byte <= '0;
      sck_q   <= 1'b0;
    end else begin
      nss_q <= {nss_q[1:0], nss_i};
      done  <= 1'b0;
      if (abort)        mst <= 1'b0;
      else if (mst_set) mst <= 1'b1;
      if (abort)          fault <= 1'b1;
      else if (fault_clr) fault <= 1'b0;
      if (abort) begin
        busy <= 1'b0;
      end else if (go) begin
        busy  <= 1'b1;
        cnt   <= '0;
        edg   <= '0;
        sh    <= tx_byte;
        sck_q <= cfg_cpol;
      end else if (busy) begin
        cnt <= tick ? '0 : cnt + 1'b1;
        if (tick) begin
          sck_q <= ~sck_q;
          edg   <= edg + 1'b1;
          if (edg == ELAST) busy <= 1'b0;
        end
        if (shf) sh <= {sh[DW-2:0], 1'b0};
        if (smp) rsh <= rnext;
        if (smp_last) begin
          rx_byte <= rnext;
          done    <= 1'b1;
        end
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4

  AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !fault_clr) |=> fault); // R7

  AST_START_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    (!mst && !busy) |=> !busy); // R5

  AST_FAULT_DROPS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> (!mst && !busy && !done)); // R6

  AST_NO_FAULT_OTHER_MODES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode != 2'b01 && !fault) |=> !fault); // R8

  AST_SCK_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && $stable(cfg_cpol)) |-> $stable(sck_o)); // R2

endmodule

// File: tb/spi_mm_master_bench.sv
`timescale 1ns/1ps
module spi_mm_master_bench;
  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_mode = 2'b11;
  logic cfg_cpol = 0, cfg_cpha = 0;
  logic [7:0] cfg_div = 0;
  logic mst_set = 0, start = 0, fault_clr = 0, nss_i = 1;
  logic [7:0] tx_byte = 0;
  logic miso_i = 0;
  logic mst, busy, done, fault, sck_o, mosi_o, nss_o, nss_oe;
  logic [7:0] rx_byte;

  int total = 0, bad = 0;
  bit finished = 0;

  spi_mm_master u_spi_mm_master (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_div(cfg_div), .mst_set(mst_set), .mst(mst),
    .start(start), .tx_byte(tx_byte), .rx_byte(rx_byte), .busy(busy),
    .done(done), .fault(fault), .fault_clr(fault_clr), .sck_o(sck_o),
    .mosi_o(mosi_o), .miso_i(miso_i), .nss_i(nss_i), .nss_o(nss_o),
    .nss_oe(nss_oe));

  always #4 clk = ~clk;

  // slave model: owns every variable below
  logic [7:0] sl_data = 0;
  int sl_seq = 0, seen_seq = 0;
  logic [7:0] stx = 0, srx = 0;
  int nlead = 0, per_bad = 0, ndone = 0, cyc = 0, tlead = 0;
  logic psck = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (seen_seq != sl_seq) begin
      seen_seq = sl_seq;
      stx = sl_data; srx = 0; nlead = 0; per_bad = 0; ndone = 0;
      miso_i = sl_data[7];
    end else if (sck_o != psck) begin
      if (sck_o != cfg_cpol) begin
        nlead = nlead + 1;
        if (nlead > 1 && (cyc - tlead) != 2 * (cfg_div + 1)) per_bad = per_bad + 1;
        tlead = cyc;
        if (!cfg_cpha) srx = {srx[6:0], mosi_o};
        else begin
          if (nlead > 1) stx = {stx[6:0], 1'b0};
          miso_i = stx[7];
        end
      end else begin
        if (cfg_cpha) srx = {srx[6:0], mosi_o};
        else begin
          stx = {stx[6:0], 1'b0};
          miso_i = stx[7];
        end
      end
    end
    if (done) ndone = ndone + 1;
    psck = sck_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic begin_xfer(input bit pol, input bit pha, input logic [7:0] dv,
                            input logic [7:0] tx, input logic [7:0] sl);
    @(negedge clk);
    cfg_cpol = pol; cfg_cpha = pha; cfg_div = dv;
    tick(2);
    sl_data = sl; sl_seq++;
    tick(2);
    tx_byte = tx; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy === 1'b1, "R4 busy after start", busy, 1);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 600 && busy; i++) @(negedge clk);
    tick(2);
  endtask

  task automatic check_xfer(input string tag, input logic [7:0] tx, input logic [7:0] sl);
    chk(nlead == 8, {tag, " R2 pulse count"}, nlead, 8);
    chk(per_bad == 0, {tag, " R2 period"}, per_bad, 0);
    chk(sck_o == cfg_cpol, {tag, " R2 idle level"}, sck_o, cfg_cpol);
    chk(srx == tx, {tag, " R1 R3 mosi byte"}, srx, tx);
    chk(rx_byte == sl, {tag, " R1 R3 rx_byte"}, rx_byte, sl);
    chk(ndone == 1, {tag, " R4 done pulse"}, ndone, 1);
  endtask

  // {cpol, cpha, div[3:0], tx[7:0], slave[7:0]}
  localparam logic [21:0] VEC [8] = '{
    {1'b0, 1'b0, 4'd0, 8'hA5, 8'h3C},
    {1'b0, 1'b1, 4'd0, 8'h81, 8'h7E},
    {1'b1, 1'b0, 4'd0, 8'h01, 8'h80},
    {1'b1, 1'b1, 4'd0, 8'hFE, 8'h55},
    {1'b0, 1'b0, 4'd1, 8'h6D, 8'hC2},
    {1'b0, 1'b1, 4'd2, 8'h00, 8'hFF},
    {1'b1, 1'b0, 4'd5, 8'hFF, 8'h00},
    {1'b1, 1'b1, 4'd3, 8'h96, 8'h69}
  };

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    chk(!mst && !busy && !fault && !done, "R10 reset flags", {mst, busy, fault, done}, 0);
    chk(rx_byte == 8'h00, "R10 reset rx_byte", rx_byte, 0);

    // R5: start while not master
    tx_byte = 8'hAA; start = 1;
    tick(1);
    start = 0;
    tick(1);
    chk(busy == 0 && sck_o == cfg_cpol, "R5 start without master", busy, 0);

    mst_set = 1;
    tick(1);
    mst_set = 0;
    chk(mst == 1, "R5 master taken", mst, 1);

    for (int v = 0; v < 8; v++) begin
      begin_xfer(VEC[v][21], VEC[v][20], {4'd0, VEC[v][19:16]}, VEC[v][15:8], VEC[v][7:0]);
      wait_idle();
      check_xfer($sformatf("vec%0d", v), VEC[v][15:8], VEC[v][7:0]);
    end

    // R5: second start during a transfer
    begin_xfer(0, 0, 8'd2, 8'hC3, 8'h5A);
    tick(10);
    tx_byte = 8'h0F; start = 1;
    tick(1);
    start = 0;
    wait_idle();
    check_xfer("R5 restart ignored", 8'hC3, 8'h5A);

    // R9: select pin roles
    for (int m = 0; m < 4; m++) begin
      cfg_mode = m[1:0];
      #1;
      chk(nss_oe == m[1], "R9 nss_oe", nss_oe, m[1]);
      chk(nss_o == (m[1] ? m[0] : 1'b1), "R9 nss_o", nss_o, m[1] ? m[0] : 1);
    end

    // R8: NSS drop in modes 00 and 10 is ignored
    for (int m = 0; m < 3; m += 2) begin
      cfg_mode = m[1:0]; nss_i = 1;
      begin_xfer(1, 0, 8'd1, 8'h3A, 8'hB4);
      tick(6);
      nss_i = 0;
      wait_idle();
      check_xfer($sformatf("R8 mode%0d", m), 8'h3A, 8'hB4);
      chk(fault == 0 && mst == 1, "R8 no fault", fault, 0);
      nss_i = 1;
      tick(4);
    end

    // R6: mode fault aborts
    cfg_mode = 2'b01; nss_i = 1;
    tick(4);
    begin_xfer(0, 1, 8'd3, 8'h77, 8'h11);
    tick(10);
    nss_i = 0;
    tick(5);
    chk(busy == 0, "R6 transfer aborted", busy, 0);
    chk(mst == 0, "R6 master dropped", mst, 0);
    chk(fault == 1, "R6 fault set", fault, 1);
    chk(sck_o == cfg_cpol, "R6 sck idle", sck_o, cfg_cpol);
    tick(70);
    chk(ndone == 0, "R6 no done on abort", ndone, 0);
    chk(fault == 1, "R7 fault sticky", fault, 1);
    tx_byte = 8'h12; start = 1;
    tick(1);
    start = 0;
    tick(2);
    chk(busy == 0, "R5 start after fault ignored", busy, 0);
    fault_clr = 1;
    tick(1);
    fault_clr = 0;
    chk(fault == 0, "R7 fault cleared", fault, 0);

    // R6: drop while not master has no effect
    nss_i = 1;
    tick(5);
    nss_i = 0;
    tick(6);
    chk(fault == 0, "R6 no fault when not master", fault, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule